// File: doc/BRIEF.md
# Serial Port Status and Interrupt Unit

This block keeps the receive error flags, the interrupt factor flags and the interrupt mask bits for one serial port channel. It sits next to an asynchronous transceiver. The transceiver sends it single-cycle pulses for four events: a parity mismatch, a stop bit sampled low, a received character moved into the receive buffer, and the transmit shift register running empty. The block also takes a receiver-enable level and an asynchronous-mode indicator.

Software reads and writes the flags and masks over a small register bus. Reads are combinational and writes take effect at the clock edge. Every flag is cleared by writing a one to its bit. The block drives one level-sensitive interrupt request. That request stays high while any pending factor has its mask bit set.

Top module: `ssi_status_unit`

## Requirements
- R1: After a synchronous reset, both error flags, all three factor flags and all three mask bits are 0, and `irq` is low.
- R2: A pulse on `ev_parity` sets the parity error flag (address 0, bit 0) at the next clock edge, but only while `async_mode` and `rx_enable` are both 1. At other times the pulse is ignored.
- R3: A pulse on `ev_frame` sets the framing error flag (address 0, bit 1) at the next clock edge, but only while `async_mode` and `rx_enable` are both 1.
- R4: Writing address 0 clears each error flag whose data bit is 1. A 0 data bit leaves that flag unchanged.
- R5: While `rx_enable` is 0, both error flags read 0 from the next clock edge on, and error events cannot set them.
- R6: Address 1 holds the mask bits, which can be read and written: bit 0 for receive complete, bit 1 for transmit complete, bit 2 for receive error. A 1 enables the interrupt.
- R7: Address 2 holds the factor flags, with the same bit order as the masks. `ev_rx_done` sets bit 0 and `ev_tx_done` sets bit 1. An accepted parity or framing event sets bit 2. Each factor is set whatever its mask holds.
- R8: Writing address 2 clears each factor flag whose data bit is 1. A 0 data bit leaves that flag unchanged.
- R9: If a hardware set and a write-1 clear reach the same flag in one cycle, the flag ends up at 1.
- R10: `irq` is high exactly when some factor flag and its mask bit are both 1. It stays high until that condition ends.
- R11: Bit 3 of every register reads 0 and address 3 reads 0. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_enable | input | 1 | Receiver enable level |
| async_mode | input | 1 | Channel is in asynchronous mode |
| ev_parity | input | 1 | Parity mismatch pulse |
| ev_frame | input | 1 | Stop bit sampled low pulse |
| ev_rx_done | input | 1 | Received data moved to buffer pulse |
| ev_tx_done | input | 1 | Transmit shift register empty pulse |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check the following on every cycle:
- a hardware event always lands in its flag, even when a clear arrives in the same cycle;
- a disabled receiver forces the error flags to 0;
- a parity flag never rises outside asynchronous mode;
- the masks hold their value when no mask write occurs.

Some behaviour can only be shown by the bench's scenarios:
- the exact register layout seen over the bus;
- that a write of 0 leaves a flag alone, and that clears act bit by bit;
- that a factor is latched while its mask is off;
- that the request rises and falls as masks and factors change.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    localparam int DATA_W  = 4;
    localparam int ADDR_W  = 2;
    localparam int N_ERR   = 2;
    localparam int N_CAUSE = 3;

    // bit positions inside the error register
    localparam int ERR_PARITY = 0;
    localparam int ERR_FRAME  = 1;

    // bit positions inside the mask and factor registers
    localparam int CAUSE_RXDONE = 0;
    localparam int CAUSE_TXDONE = 1;
    localparam int CAUSE_RXERR  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ERR  = 2'd0,
        REG_MASK = 2'd1,
        REG_FACT = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic parity;
        logic frame;
        logic rx_done;
        logic tx_done;
    } events_t;

    typedef struct packed {
        logic                    err_we;
        logic                    mask_we;
        logic                    fact_we;
        logic [DATA_W-1:0]       data;
    } wr_req_t;

    // set has priority over a write-1 clear
    function automatic logic flag_next(input logic q, input logic set, input logic clr);
        return set | (q & ~clr);
    endfunction

endpackage

// File: rtl/ssi_err_bank.sv
module ssi_err_bank #(
    parameter int N = ssi_pkg::N_ERR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_enable,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    import ssi_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || !rx_enable) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= flag_next(q[i], set[i], clr[i]);
            end
        end
    end

endmodule

// File: rtl/ssi_irq_bank.sv
module ssi_irq_bank #(
    parameter int N = ssi_pkg::N_CAUSE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] fac_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    import ssi_pkg::*;

    logic [N-1:0] active;

    for (genvar i = 0; i < N; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst) begin
                fac_q[i]  <= 1'b0;
                mask_q[i] <= 1'b0;
            end else begin
                fac_q[i] <= flag_next(fac_q[i], set[i], clr[i]);
                if (mask_we) begin
                    mask_q[i] <= mask_wd[i];
                end
            end
        end
        assign active[i] = fac_q[i] & mask_q[i];
    end

    assign irq = |active;

endmodule

// File: rtl/ssi_regif.sv
module ssi_regif #(
    parameter int DW = ssi_pkg::DATA_W,
    parameter int AW = ssi_pkg::ADDR_W,
    parameter int NE = ssi_pkg::N_ERR,
    parameter int NC = ssi_pkg::N_CAUSE
) (
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [NE-1:0] err_q,
    input  logic [NC-1:0] mask_q,
    input  logic [NC-1:0] fac_q,
    output logic [NE-1:0] err_clr,
    output logic [NC-1:0] fac_clr,
    output logic          mask_we,
    output logic [NC-1:0] mask_wd,
    output logic [DW-1:0] bus_rdata
);
    import ssi_pkg::*;

    wr_req_t  req;
    reg_sel_e sel;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        req         = '0;
        req.data    = bus_wdata;
        if (bus_sel && bus_wr) begin
            unique case (sel)
                REG_ERR:  req.err_we  = 1'b1;
                REG_MASK: req.mask_we = 1'b1;
                REG_FACT: req.fact_we = 1'b1;
                default:  ;
            endcase
        end
    end

    assign err_clr = req.err_we  ? req.data[NE-1:0] : '0;
    assign fac_clr = req.fact_we ? req.data[NC-1:0] : '0;
    assign mask_we = req.mask_we;
    assign mask_wd = req.data[NC-1:0];

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_ERR:  bus_rdata[NE-1:0] = err_q;
            REG_MASK: bus_rdata[NC-1:0] = mask_q;
            REG_FACT: bus_rdata[NC-1:0] = fac_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ssi_status_unit.sv
module ssi_status_unit (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_enable,
    input  logic                       async_mode,
    input  logic                       ev_parity,
    input  logic                       ev_frame,
    input  logic                       ev_rx_done,
    input  logic                       ev_tx_done,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ssi_pkg::ADDR_W-1:0] bus_addr,
    input  logic [ssi_pkg::DATA_W-1:0] bus_wdata,
    output logic [ssi_pkg::DATA_W-1:0] bus_rdata,
    output logic                       irq
);
    import ssi_pkg::*;

    events_t            ev;
    logic [N_ERR-1:0]   err_set, err_clr, err_q;
    logic [N_CAUSE-1:0] fac_set, fac_clr, fac_q, mask_q, mask_wd;
    logic               mask_we;
    logic               rx_err_ok;

    assign ev = '{parity: ev_parity, frame: ev_frame,
                  rx_done: ev_rx_done, tx_done: ev_tx_done};

    // error events count only when the receiver runs in asynchronous mode
    always_comb begin
        err_set             = '0;
        err_set[ERR_PARITY] = ev.parity & async_mode & rx_enable;
        err_set[ERR_FRAME]  = ev.frame  & async_mode & rx_enable;
    end

    assign rx_err_ok = |err_set;

    always_comb begin
        fac_set               = '0;
        fac_set[CAUSE_RXDONE] = ev.rx_done;
        fac_set[CAUSE_TXDONE] = ev.tx_done;
        fac_set[CAUSE_RXERR]  = rx_err_ok;
    end

    ssi_regif #(
        .DW(DATA_W), .AW(ADDR_W), .NE(N_ERR), .NC(N_CAUSE)
    ) u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .err_q     (err_q),
        .mask_q    (mask_q),
        .fac_q     (fac_q),
        .err_clr   (err_clr),
        .fac_clr   (fac_clr),
        .mask_we   (mask_we),
        .mask_wd   (mask_wd),
        .bus_rdata (bus_rdata)
    );

    ssi_err_bank #(.N(N_ERR)) u_err (
        .clk       (clk),
        .rst       (rst),
        .rx_enable (rx_enable),
        .set       (err_set),
        .clr       (err_clr),
        .q         (err_q)
    );

    ssi_irq_bank #(.N(N_CAUSE)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set     (fac_set),
        .clr     (fac_clr),
        .mask_we (mask_we),
        .mask_wd (mask_wd),
        .fac_q   (fac_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

endmodule

// File: rtl/ssi_status_chk.sv
module ssi_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_enable,
    input logic       async_mode,
    input logic       ev_parity,
    input logic       ev_frame,
    input logic       ev_rx_done,
    input logic       ev_tx_done,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       irq,
    input logic [1:0] err_q,
    input logic [2:0] mask_q,
    input logic [2:0] fac_q
);

    // R9 and R7: an event always lands in its factor flag
    p_rx_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done |=> fac_q[0]);

    p_tx_done_sets_r7: assert property (@(posedge clk) disable iff (rst)
        ev_tx_done |=> fac_q[1]);

    // R7: an accepted error event raises the receive-error factor
    p_rx_err_sets_r7: assert property (@(posedge clk) disable iff (rst)
        ((ev_parity || ev_frame) && async_mode && rx_enable) |=> fac_q[2]);

    // R5: a disabled receiver empties the error flags
    p_rxoff_clears_r5: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> (err_q == 2'b00));

    // R2: the parity flag never rises without an accepted parity event
    p_parity_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q[0]) |-> $past(ev_parity && async_mode && rx_enable));

    // R3: an accepted framing event lands in its flag
    p_frame_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_frame && async_mode && rx_enable) |=> err_q[1]);

    // R6: masks hold when no mask write is made
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == 2'd1) |=> $stable(mask_q));

    // R10: an enabled pending factor drives the request
    p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
        ((fac_q & mask_q) != 3'b000) |-> irq);

endmodule

bind ssi_status_unit ssi_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_enable  (rx_enable),
    .async_mode (async_mode),
    .ev_parity  (ev_parity),
    .ev_frame   (ev_frame),
    .ev_rx_done (ev_rx_done),
    .ev_tx_done (ev_tx_done),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .irq        (irq),
    .err_q      (err_q),
    .mask_q     (mask_q),
    .fac_q      (fac_q)
);

// File: tb/ssi_status_unit_bench.sv
`timescale 1ns/1ps
module ssi_status_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b1, async_mode = 1'b1;
    logic       ev_parity = 1'b0, ev_frame = 1'b0, ev_rx_done = 1'b0, ev_tx_done = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ssi_status_unit u_ssi_status_unit (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .async_mode(async_mode),
        .ev_parity(ev_parity), .ev_frame(ev_frame), .ev_rx_done(ev_rx_done),
        .ev_tx_done(ev_tx_done), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares every read cycle with the next queued expectation
    always @(posedge clk) begin
        if (!rst && bus_sel && !bus_wr && exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({irq, bus_rdata} !== e) begin
                fails++;
                $display("FAIL %s: irq/rdata actual %b/%b expected %b/%b",
                         t, irq, bus_rdata, e[4], e[3:0]);
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [3:0] d, input logic i, input string t);
        @(negedge clk);
        exp_q.push_back({i, d});
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // 0 parity, 1 frame, 2 rx done, 3 tx done
    task automatic pulse(input int k);
        @(negedge clk);
        ev_parity = (k == 0); ev_frame = (k == 1);
        ev_rx_done = (k == 2); ev_tx_done = (k == 3);
        @(negedge clk);
        ev_parity = 0; ev_frame = 0; ev_rx_done = 0; ev_tx_done = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(2'd0, 4'b0000, 1'b0, "R1 err after reset");
        rd(2'd1, 4'b0000, 1'b0, "R1 mask after reset");
        rd(2'd2, 4'b0000, 1'b0, "R1 factor after reset");

        pulse(0);
        rd(2'd0, 4'b0001, 1'b0, "R2 parity set");
        pulse(1);
        rd(2'd0, 4'b0011, 1'b0, "R3 framing set");
        rd(2'd2, 4'b0100, 1'b0, "R7 rx error factor");

        wr(2'd0, 4'b0000);
        rd(2'd0, 4'b0011, 1'b0, "R4 write 0 no effect");
        wr(2'd0, 4'b0001);
        rd(2'd0, 4'b0010, 1'b0, "R4 clear parity only");
        wr(2'd0, 4'b0010);
        rd(2'd0, 4'b0000, 1'b0, "R4 clear framing");

        async_mode = 1'b0;
        pulse(0);
        pulse(1);
        rd(2'd0, 4'b0000, 1'b0, "R2 R3 ignored in sync mode");
        async_mode = 1'b1;

        pulse(0);
        rd(2'd0, 4'b0001, 1'b0, "R2 parity set again");
        rx_enable = 1'b0;
        rd(2'd0, 4'b0000, 1'b0, "R5 rx off clears");
        pulse(0);
        rd(2'd0, 4'b0000, 1'b0, "R5 no set while rx off");
        rx_enable = 1'b1;
        rd(2'd0, 4'b0000, 1'b0, "R5 stays clear on re-enable");

        wr(2'd2, 4'b0111);
        rd(2'd2, 4'b0000, 1'b0, "R8 clear all factors");
        pulse(2);
        rd(2'd2, 4'b0001, 1'b0, "R7 rx done with mask off");
        pulse(3);
        rd(2'd2, 4'b0011, 1'b0, "R7 tx done with mask off");
        wr(2'd2, 4'b0000);
        rd(2'd2, 4'b0011, 1'b0, "R8 write 0 no effect");
        wr(2'd2, 4'b0001);
        rd(2'd2, 4'b0010, 1'b0, "R8 clear rx done");
        wr(2'd2, 4'b0010);
        rd(2'd2, 4'b0000, 1'b0, "R8 clear tx done");

        wr(2'd1, 4'b1111);
        rd(2'd1, 4'b0111, 1'b0, "R6 R11 mask readback");
        wr(2'd1, 4'b0010);
        rd(2'd1, 4'b0010, 1'b0, "R6 mask rewrite");

        pulse(2);
        rd(2'd2, 4'b0001, 1'b0, "R10 masked factor no irq");
        pulse(3);
        rd(2'd2, 4'b0011, 1'b1, "R10 enabled factor irq");
        wr(2'd2, 4'b0010);
        rd(2'd2, 4'b0001, 1'b0, "R10 irq falls on clear");
        wr(2'd1, 4'b0111);
        rd(2'd1, 4'b0111, 1'b1, "R10 irq rises on mask");
        wr(2'd2, 4'b0001);
        rd(2'd2, 4'b0000, 1'b0, "R10 irq low when none pending");

        @(negedge clk);
        ev_tx_done = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 4'b0010;
        @(negedge clk);
        ev_tx_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(2'd2, 4'b0010, 1'b1, "R9 factor set wins");

        @(negedge clk);
        ev_parity = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 4'b0001;
        @(negedge clk);
        ev_parity = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(2'd0, 4'b0001, 1'b1, "R9 error set wins");
        wr(2'd0, 4'b0001);
        rd(2'd2, 4'b0110, 1'b1, "R7 factors after error");

        rd(2'd3, 4'b0000, 1'b1, "R11 reserved reads 0");
        wr(2'd3, 4'b1111);
        rd(2'd1, 4'b0111, 1'b1, "R11 reserved write leaves mask");
        rd(2'd2, 4'b0110, 1'b1, "R11 reserved write leaves factors");
        rd(2'd0, 4'b0000, 1'b1, "R11 reserved write leaves errors");

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule